// File: doc/BRIEF.md
# NAND Flash Host Bus Bridge

This block connects a 16-bit memory-mapped host register bus to an 8-bit raw NAND flash device. Software steers the device through a single mode register whose bits drive the chip-select, command-latch and address-latch pins. It then moves bytes through a data register, where one 16-bit bus access becomes two NAND byte cycles and an 8-bit access becomes one.

A status register shows the device busy line. A sticky ready flag is set when the device finishes an operation. Software can route that flag to an interrupt through a mask register, and clears it by writing ones to the flag register. Each NAND read or write strobe is held low for `STROBE_LO` clocks and then high for `STROBE_HI` clocks. The host handshake is a request held until a one-cycle acknowledge.

Top module: `nand_bus_bridge`

## Requirements
- R1: Register offsets on `bus_addr` are: data 0, mode 4, status 5, flags 6, mask 7. Mode and mask read back the byte last written in `bus_rdata[7:0]`, with `bus_rdata[15:8]` zero.
- R2: Mode bit 4 drives the chip select (`nand_ce_n` = inverse of bit 4), bit 1 drives `nand_ale` and bit 0 drives `nand_cle`. Code 0x94 selects data cycles, 0x95 command cycles, 0x96 address cycles, and 0x00 deselects the device. The pins show the new code by the cycle `bus_ack` is high.
- R3: A 16-bit data write sends `bus_wdata[7:0]` in the first NAND write cycle and `bus_wdata[15:8]` in the second. An 8-bit data write sends only `bus_wdata[7:0]`. Under mode 0x95 the byte is latched with `nand_cle` high, and under 0x96 with `nand_ale` high.
- R4: A 16-bit data read performs two NAND read cycles. The first byte returns in `bus_rdata[7:0]` and the second in `bus_rdata[15:8]`.
- R5: An 8-bit data read performs one NAND read cycle and returns the byte in `bus_rdata[7:0]`, with the upper byte zero.
- R6: Every NAND strobe stays low for exactly `STROBE_LO` clocks. Between the two byte cycles of one access, the strobes stay high for exactly `STROBE_HI` clocks.
- R7: `bus_ack` is a single-cycle pulse. For a data access it is raised only after every byte cycle of that access has completed, with both strobes high.
- R8: When mode bit 7 is 0, a data write produces no NAND write strobe but is still acknowledged.
- R9: Status bit 7 reads 1 while `nand_rb` is low (busy) and 0 when it is high. All other status bits read 0.
- R10: A rising edge on `nand_rb` sets the ready flag, which reads in bit 0 of the flags register. The flag stays set until a write with bit 0 set clears it; writing 0x0F clears all flags.
- R11: `irq` is high when mask bit 7 is 1 and any flag ANDed with mask bits 3:0 is 1. Writing 0x81 to the mask enables the ready interrupt, and 0x00 disables it. The mask resets to 0.
- R12: After reset: `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1; `nand_cle`, `nand_ale`, `nand_dq_oe`, `irq` and `bus_ack` are 0; mode, mask and flags read 0.
- R13: `nand_we_n` and `nand_re_n` are never low together. `nand_dq_oe` is high only during write cycles, never while `nand_re_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until `bus_ack` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Masked ready interrupt |
| nand_ce_n | output | 1 | NAND chip select, active low |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ale | output | 1 | NAND address latch enable |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| nand_dq_out | output | 8 | Byte driven toward the NAND |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Byte returned by the NAND |
| nand_rb | input | 1 | NAND ready/busy, 1 = ready |

## Verification
On every cycle, the assertions check that the two strobes are mutually exclusive and that the data bus is never driven during a read. They also check that the acknowledge is a single pulse that never overlaps a strobe, that a ready rise always sets the flag, that the flag never drops without a clear, and that an unset master mask bit keeps the interrupt low. The byte order of packing and unpacking, the latch levels seen under each mode code, the exact strobe widths, the write gate and the mask and clear sequences depend on data values and on the order of accesses. Only the bench's directed scenarios, with a behavioural NAND model, can show these.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_MODE = 3'd4;
  localparam logic [2:0] OFF_STAT = 3'd5;
  localparam logic [2:0] OFF_FLAG = 3'd6;
  localparam logic [2:0] OFF_MASK = 3'd7;

  localparam int MODE_WR_EN = 7;
  localparam int MODE_CE    = 4;
  localparam int MODE_ALE   = 1;
  localparam int MODE_CLE   = 0;

  typedef enum logic [1:0] {HS_IDLE, HS_XFER, HS_ACK} host_state_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LOW, SQ_HIGH} seq_state_t;

  // first NAND byte in the low half of the bus word
  function automatic logic [15:0] pack_bytes(input logic [7:0] first_b,
                                             input logic [7:0] second_b);
    return {second_b, first_b};
  endfunction

  // status byte: bit 7 reports busy
  function automatic logic [7:0] status_byte(input logic rb_ready);
    return {~rb_ready, 7'b0};
  endfunction

  function automatic logic irq_eval(input logic [3:0] flags,
                                    input logic [7:0] mask);
    return mask[7] & (|(flags & mask[3:0]));
  endfunction

endpackage

// File: rtl/nbb_byte_seq.sv
module nbb_byte_seq #(
  parameter int STROBE_LO = 3,
  parameter int STROBE_HI = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_write,
  input  logic [7:0] wr_byte,
  input  logic [7:0] dq_in,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] dq_out,
  output logic       dq_oe,
  output logic [7:0] rd_byte,
  output logic       done
);
  import nbb_pkg::*;

  localparam int MAXW = (STROBE_LO > STROBE_HI) ? STROBE_LO : STROBE_HI;
  localparam int CW   = $clog2(MAXW + 1);

  seq_state_t    st_q;
  logic [CW-1:0] cnt_q;
  logic          wr_q;
  logic [7:0]    dq_q;
  logic [7:0]    rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      wr_q  <= 1'b0;
      dq_q  <= 8'h00;
      rd_q  <= 8'h00;
    end else if (start) begin
      st_q  <= SQ_LOW;
      cnt_q <= CW'(STROBE_LO - 1);
      wr_q  <= is_write;
      dq_q  <= wr_byte;
    end else begin
      case (st_q)
        SQ_LOW: begin
          if (cnt_q == '0) begin
            if (!wr_q) rd_q <= dq_in;
            st_q  <= SQ_HIGH;
            cnt_q <= CW'(STROBE_HI - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SQ_HIGH: begin
          if (cnt_q == '0) st_q <= SQ_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign we_n    = !((st_q == SQ_LOW) && wr_q);
  assign re_n    = !((st_q == SQ_LOW) && !wr_q);
  assign dq_oe   = wr_q && (st_q != SQ_IDLE);
  assign dq_out  = dq_q;
  assign rd_byte = rd_q;
  assign done    = (st_q == SQ_HIGH) && (cnt_q == '0);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n)); // R13
  AST_OE_NOT_READING: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> re_n); // R13

endmodule

// File: rtl/nbb_ready_irq.sv
module nbb_ready_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rb_in,
  input  logic       clr_stb,
  input  logic [3:0] clr_mask,
  input  logic [7:0] mask,
  output logic       rb_ready,
  output logic [3:0] flags,
  output logic       irq
);
  import nbb_pkg::*;

  logic [1:0] sync_q;
  logic       prev_q;
  logic       ready_flag;
  logic       rise_evt;
  logic       clear_evt;

  assign rise_evt  = sync_q[1] & ~prev_q;
  assign clear_evt = clr_stb & clr_mask[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= 2'b11;
      prev_q     <= 1'b1;
      ready_flag <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rb_in};
      prev_q <= sync_q[1];
      if (rise_evt)       ready_flag <= 1'b1;
      else if (clear_evt) ready_flag <= 1'b0;
    end
  end

  assign rb_ready = sync_q[1];
  assign flags    = {3'b000, ready_flag};
  assign irq      = irq_eval(flags, mask);

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> ready_flag); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_flag && !clear_evt) |=> ready_flag); // R10
  AST_IRQ_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mask[7] |-> !irq); // R11

endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge #(
  parameter int STROBE_LO = 3,
  parameter int STROBE_HI = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic        bus_wide,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_ack,
  output logic        irq,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_out,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_in,
  input  logic        nand_rb
);
  import nbb_pkg::*;

  host_state_t hs_q;
  logic [7:0]  mode_q;
  logic [7:0]  mask_q;
  logic        wide_q;
  logic        wr_q;
  logic        idx_q;
  logic [7:0]  first_q;
  logic [15:0] wdata_q;
  logic [15:0] rdata_q;
  logic        ack_q;

  logic        accept;
  logic        is_data;
  logic        launch0;
  logic        last_byte;
  logic        seq_start;
  logic        seq_is_write;
  logic [7:0]  seq_byte;
  logic [7:0]  seq_rd;
  logic        seq_done;
  logic        clr_stb;
  logic        rb_ready;
  logic [3:0]  flags;

  assign accept    = (hs_q == HS_IDLE) && bus_req;
  assign is_data   = (bus_addr == OFF_DATA);
  assign launch0   = accept && is_data && (!bus_we || mode_q[MODE_WR_EN]);
  assign last_byte = !wide_q || idx_q;
  assign seq_start = launch0 || ((hs_q == HS_XFER) && seq_done && !last_byte);
  assign seq_is_write = (hs_q == HS_IDLE) ? bus_we : wr_q;
  assign seq_byte     = (hs_q == HS_IDLE) ? bus_wdata[7:0] : wdata_q[15:8];
  assign clr_stb   = accept && bus_we && (bus_addr == OFF_FLAG);

  nbb_byte_seq #(.STROBE_LO(STROBE_LO), .STROBE_HI(STROBE_HI)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (seq_start),
    .is_write (seq_is_write),
    .wr_byte  (seq_byte),
    .dq_in    (nand_dq_in),
    .we_n     (nand_we_n),
    .re_n     (nand_re_n),
    .dq_out   (nand_dq_out),
    .dq_oe    (nand_dq_oe),
    .rd_byte  (seq_rd),
    .done     (seq_done)
  );

  nbb_ready_irq u_rdy (
    .clk      (clk),
    .rst_n    (rst_n),
    .rb_in    (nand_rb),
    .clr_stb  (clr_stb),
    .clr_mask (bus_wdata[3:0]),
    .mask     (mask_q),
    .rb_ready (rb_ready),
    .flags    (flags),
    .irq      (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= HS_IDLE;
      mode_q  <= 8'h00;
      mask_q  <= 8'h00;
      wide_q  <= 1'b0;
      wr_q    <= 1'b0;
      idx_q   <= 1'b0;
      first_q <= 8'h00;
      wdata_q <= 16'h0000;
      rdata_q <= 16'h0000;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      case (hs_q)
        HS_IDLE: begin
          if (launch0) begin
            hs_q    <= HS_XFER;
            wide_q  <= bus_wide;
            wr_q    <= bus_we;
            idx_q   <= 1'b0;
            wdata_q <= bus_wdata;
          end else if (accept) begin
            hs_q  <= HS_ACK;
            ack_q <= 1'b1;
            if (bus_we) begin
              if (bus_addr == OFF_MODE) mode_q <= bus_wdata[7:0];
              if (bus_addr == OFF_MASK) mask_q <= bus_wdata[7:0];
              rdata_q <= 16'h0000;
            end else begin
              case (bus_addr)
                OFF_MODE: rdata_q <= {8'h00, mode_q};
                OFF_STAT: rdata_q <= {8'h00, status_byte(rb_ready)};
                OFF_FLAG: rdata_q <= {12'h000, flags};
                OFF_MASK: rdata_q <= {8'h00, mask_q};
                default:  rdata_q <= 16'h0000;
              endcase
            end
          end
        end
        HS_XFER: begin
          if (seq_done) begin
            if (!idx_q) first_q <= seq_rd;
            if (last_byte) begin
              hs_q  <= HS_ACK;
              ack_q <= 1'b1;
              if (wr_q)        rdata_q <= 16'h0000;
              else if (wide_q) rdata_q <= pack_bytes(first_q, seq_rd);
              else             rdata_q <= pack_bytes(seq_rd, 8'h00);
            end else begin
              idx_q <= 1'b1;
            end
          end
        end
        default: hs_q <= HS_IDLE;
      endcase
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
  assign nand_ce_n = ~mode_q[MODE_CE];
  assign nand_cle  = mode_q[MODE_CLE];
  assign nand_ale  = mode_q[MODE_ALE];

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack); // R7
  AST_ACK_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> (nand_we_n && nand_re_n)); // R7

endmodule

// File: tb/nand_bus_bridge_bench.sv
module nand_bus_bridge_bench;

  localparam int LO = 3;
  localparam int HI = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_wide = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        bus_ack;
  logic        irq;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [7:0]  nand_dq_out;
  logic        nand_dq_oe;
  logic [7:0]  nand_dq_in = 8'h00;
  logic        nand_rb = 1'b1;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  nand_bus_bridge #(.STROBE_LO(LO), .STROBE_HI(HI)) u_nand_bus_bridge (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq(irq),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  // behavioural NAND: log writes, serve reads
  logic [7:0] wr_log [0:63];
  logic       cle_log [0:63];
  logic       ale_log [0:63];
  int         wr_cnt = 0;
  logic [7:0] rd_src [0:7];
  int         rd_cnt = 0;

  always @(posedge nand_we_n) begin
    if (rst_n && wr_cnt < 64) begin
      wr_log[wr_cnt]  = nand_dq_out;
      cle_log[wr_cnt] = nand_cle;
      ale_log[wr_cnt] = nand_ale;
      wr_cnt = wr_cnt + 1;
    end
  end

  always @(negedge nand_re_n) begin
    if (rst_n) begin
      nand_dq_in = rd_src[rd_cnt % 8];
      rd_cnt = rd_cnt + 1;
    end
  end

  // strobe width monitor
  int lo_run = 0, hi_run = 0, last_lo = 0, last_hi = 0;
  always @(negedge clk) begin
    if (!nand_we_n || !nand_re_n) begin
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0;
      lo_run = lo_run + 1;
    end else begin
      if (lo_run != 0) last_lo = lo_run;
      lo_run = 0;
      hi_run = hi_run + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_xfer(input logic we, input logic wide, input logic [2:0] addr,
                          input logic [15:0] wdata, output logic [15:0] rdata);
    int n;
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_wide = wide;
    bus_addr = addr; bus_wdata = wdata;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bus_ack && n < 200);
    rdata = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] addr, input logic [15:0] d);
    logic [15:0] dummy;
    bus_xfer(1'b1, 1'b0, addr, d, dummy);
  endtask

  task automatic t_reset;
    logic [15:0] r;
    chk("R12", "ce_n", nand_ce_n, 1);
    chk("R12", "strobes", {nand_we_n, nand_re_n}, 2'b11);
    chk("R12", "cle/ale/oe", {nand_cle, nand_ale, nand_dq_oe}, 0);
    chk("R12", "irq/ack", {irq, bus_ack}, 0);
    bus_xfer(1'b0, 1'b0, 3'd4, 0, r); chk("R12", "mode", r, 0);
    bus_xfer(1'b0, 1'b0, 3'd7, 0, r); chk("R12", "mask", r, 0);
    bus_xfer(1'b0, 1'b0, 3'd6, 0, r); chk("R12", "flags", r, 0);
  endtask

  task automatic t_mode_codes;
    logic [15:0] r;
    wr_reg(3'd4, 16'h0095);
    chk("R2", "0x95 pins ce_n,cle,ale", {nand_ce_n, nand_cle, nand_ale}, 3'b010);
    wr_reg(3'd4, 16'h0096);
    chk("R2", "0x96 pins ce_n,cle,ale", {nand_ce_n, nand_cle, nand_ale}, 3'b001);
    wr_reg(3'd4, 16'h0094);
    chk("R2", "0x94 pins ce_n,cle,ale", {nand_ce_n, nand_cle, nand_ale}, 3'b000);
    wr_reg(3'd4, 16'h0000);
    chk("R2", "0x00 pins ce_n,cle,ale", {nand_ce_n, nand_cle, nand_ale}, 3'b100);
    wr_reg(3'd4, 16'hAB6C);
    bus_xfer(1'b0, 1'b0, 3'd4, 0, r); chk("R1", "mode readback", r, 16'h006C);
    wr_reg(3'd7, 16'h0042);
    bus_xfer(1'b0, 1'b0, 3'd7, 0, r); chk("R1", "mask readback", r, 16'h0042);
    wr_reg(3'd7, 16'h0000);
  endtask

  task automatic t_cmd_addr_write;
    int b;
    logic [15:0] r;
    wr_reg(3'd4, 16'h0095);
    b = wr_cnt;
    bus_xfer(1'b1, 1'b0, 3'd0, 16'h33FF, r);
    chk("R3", "command byte count", wr_cnt - b, 1);
    chk("R3", "command byte", wr_log[b], 8'hFF);
    chk("R3", "command cle/ale", {cle_log[b], ale_log[b]}, 2'b10);
    wr_reg(3'd4, 16'h0096);
    b = wr_cnt;
    bus_xfer(1'b1, 1'b0, 3'd0, 16'h0012, r);
    chk("R3", "address byte", wr_log[b], 8'h12);
    chk("R3", "address cle/ale", {cle_log[b], ale_log[b]}, 2'b01);
  endtask

  task automatic t_data_write16;
    int b;
    logic [15:0] r;
    wr_reg(3'd4, 16'h0094);
    b = wr_cnt;
    bus_xfer(1'b1, 1'b1, 3'd0, 16'hC3A7, r);
    chk("R7", "both byte cycles done at ack", wr_cnt - b, 2);
    chk("R3", "first byte low half", wr_log[b], 8'hA7);
    chk("R3", "second byte high half", wr_log[b+1], 8'hC3);
    chk("R6", "strobe low width", last_lo, LO);
    chk("R6", "strobe gap width", last_hi, HI);
    chk("R13", "oe released after write", nand_dq_oe, 0);
  endtask

  task automatic t_write_gate;
    int b;
    logic [15:0] r;
    wr_reg(3'd4, 16'h0014);
    b = wr_cnt;
    bus_xfer(1'b1, 1'b1, 3'd0, 16'h5566, r);
    chk("R8", "acked without strobe", bus_ack, 1);
    repeat (12) @(negedge clk);
    chk("R8", "no write cycles", wr_cnt - b, 0);
    wr_reg(3'd4, 16'h0094);
  endtask

  task automatic t_reads;
    int b;
    logic [15:0] r;
    rd_src[rd_cnt % 8]       = 8'h3C;
    rd_src[(rd_cnt + 1) % 8] = 8'hA5;
    rd_src[(rd_cnt + 2) % 8] = 8'h5A;
    b = rd_cnt;
    bus_xfer(1'b0, 1'b1, 3'd0, 0, r);
    chk("R4", "16-bit read word", r, 16'hA53C);
    chk("R4", "read cycles", rd_cnt - b, 2);
    chk("R6", "read strobe low width", last_lo, LO);
    b = rd_cnt;
    bus_xfer(1'b0, 1'b0, 3'd0, 0, r);
    chk("R5", "8-bit read", r, 16'h005A);
    chk("R5", "read cycles", rd_cnt - b, 1);
  endtask

  task automatic t_status_irq;
    logic [15:0] r;
    nand_rb = 1'b0;
    repeat (5) @(negedge clk);
    bus_xfer(1'b0, 1'b0, 3'd5, 0, r); chk("R9", "status busy", r, 16'h0080);
    bus_xfer(1'b0, 1'b0, 3'd6, 0, r); chk("R10", "no flag while busy", r, 0);
    nand_rb = 1'b1;
    repeat (5) @(negedge clk);
    bus_xfer(1'b0, 1'b0, 3'd5, 0, r); chk("R9", "status ready", r, 16'h0000);
    chk("R11", "irq masked by default", irq, 0);
    repeat (10) @(negedge clk);
    bus_xfer(1'b0, 1'b0, 3'd6, 0, r); chk("R10", "flag sticky", r, 16'h0001);
    wr_reg(3'd7, 16'h0001);
    chk("R11", "no irq without bit7", irq, 0);
    wr_reg(3'd7, 16'h0081);
    chk("R11", "irq enabled", irq, 1);
    wr_reg(3'd7, 16'h0000);
    chk("R11", "irq disabled", irq, 0);
    wr_reg(3'd7, 16'h0081);
    wr_reg(3'd6, 16'h000F);
    chk("R10", "irq after clear", irq, 0);
    bus_xfer(1'b0, 1'b0, 3'd6, 0, r); chk("R10", "flag cleared", r, 0);
    wr_reg(3'd7, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) rd_src[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_mode_codes;
    t_cmd_addr_write;
    t_data_write16;
    t_write_gate;
    t_reads;
    t_status_irq;
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule